// File: doc/BRIEF.md
# Delta-Modulation Sample Channel

This block plays back 1-bit delta-coded audio samples. A memory reader fetches sample bytes one at a time into a single-byte holding buffer. An output shifter takes each byte and applies its bits, least significant first, to a 7-bit output level. Each bit moves the level two steps up or down. The pace is set by a rate timer that counts enabled CPU clock cycles. When the shifter begins a new 8-bit cycle and the buffer is empty, the shifter plays a silent cycle of the same length instead, and the level holds during it.

Software controls the channel through four register write strobes and two inputs shared with a common status register. The four registers are control, direct level, start address and length. The two shared inputs are the channel-enable bit and the status write strobe. A sample begins at `0xC000 + 64*start` and runs for `16*length + 1` bytes. At the end, the sample either repeats or raises an interrupt flag. Each accepted fetch holds a CPU stall output high for four enabled cycles.

Fetches use a valid/ready request channel. `mem_req_valid` rises when the buffer is empty and bytes remain, and `mem_req_addr` is stable while it is high. The request completes on the cycle that both valid and `mem_req_ready` are high, and `mem_rsp_data` must carry the byte in that same cycle. Until then the memory may hold ready low for as long as it needs. Only one request is ever open. A status write that disables the channel withdraws a pending request.

Top module: `dmc_channel`

## Requirements
- R1: After reset the level is 0, the interrupt flag is 0, `active` is 0, no request is raised and the stall output is low.
- R2: A level write loads `wr_data[6:0]` into the level; `wr_data[7]` is ignored.
- R3: The control register holds interrupt enable in bit 7, repeat in bit 6 and a rate index in bits 3..0. A tick occurs once every P enabled cycles, where P for index 0..15 is 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54. A new index applies from the next timer reload.
- R4: A sample start sets the fetch address to `0xC000 + 64*start` and the byte count to `16*length + 1`.
- R5: A fetch is requested only while the buffer is empty and bytes remain. After each completed fetch the address advances by one, and 0xFFFF is followed by 0x8000. The request stays valid, with a stable address, until it is accepted.
- R6: When the last byte is fetched, the sample restarts if repeat is set. Otherwise the interrupt flag is set if interrupt enable is set, and stays clear if it is not.
- R7: A control write with bit 7 clear clears the interrupt flag, and any status write clears it.
- R8: A status write with the enable bit set starts the sample only if no bytes remain. With the enable bit clear it zeroes the byte count, which stops further fetches.
- R9: Each accepted fetch drives `cpu_stall` high for 4 enabled cycles.
- R10: On each tick of a non-silent cycle, bit 0 of the shifter adds 2 to the level if it is 1 and the level is below 126. If it is 0 and the level is above 1, 2 is subtracted. Bits are used least significant first, one per tick.
- R11: Every output cycle lasts 8 ticks. A cycle that starts with an empty buffer is silent and leaves the level unchanged.
- R12: `active` is high exactly while bytes remain to be fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | CPU cycle enable; the timer and stall count advance on it |
| ctrl_we | input | 1 | Write strobe, control register |
| level_we | input | 1 | Write strobe, direct level |
| start_we | input | 1 | Write strobe, start address register |
| length_we | input | 1 | Write strobe, length register |
| wr_data | input | 8 | Write data for the four registers |
| status_we | input | 1 | Status register write strobe |
| status_chan_en | input | 1 | Channel enable bit of the status write |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_addr | output | 16 | Fetch address |
| mem_req_ready | input | 1 | Memory accepts the request; data valid this cycle |
| mem_rsp_data | input | 8 | Fetched sample byte |
| level | output | 7 | Output level |
| active | output | 1 | Bytes remain to be fetched |
| irq | output | 1 | End-of-sample interrupt flag |
| cpu_stall | output | 1 | CPU stall indication |

## Verification
A wrong byte count or a wrong address shows on the request port at the next fetch. It appears as a wrong address, an extra request or a missing request, or as `active` falling at the wrong moment. A wrong shifter state or a wrong bit count shows on `level` within one tick. It appears as a step in the wrong direction, a step during a silent cycle, a step past the saturation bounds, or a gap between steps that differs from the rate period. A fault in the interrupt flag shows on `irq` in the cycle after the fetch or write that should change it.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int ADDR_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int LVL_W     = 7;
  localparam int RATE_W    = 4;
  localparam int PER_W     = 9;
  localparam int CNT_W     = 12;
  localparam int STALL_CYC = 4;

  // timer period in enabled CPU cycles for each rate index
  function automatic logic [PER_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
    case (idx)
      4'd0:  return 9'd428;
      4'd1:  return 9'd380;
      4'd2:  return 9'd340;
      4'd3:  return 9'd320;
      4'd4:  return 9'd286;
      4'd5:  return 9'd254;
      4'd6:  return 9'd226;
      4'd7:  return 9'd214;
      4'd8:  return 9'd190;
      4'd9:  return 9'd160;
      4'd10: return 9'd142;
      4'd11: return 9'd128;
      4'd12: return 9'd106;
      4'd13: return 9'd84;
      4'd14: return 9'd72;
      default: return 9'd54;
    endcase
  endfunction
endpackage

// File: rtl/dmc_rate_timer.sv
module dmc_rate_timer
  import dmc_pkg::*;
#(
  parameter int RW = RATE_W,
  parameter int PW = PER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ce,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  logic [PW-1:0] cnt_q;

  assign tick = cpu_ce && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= rate_period('0) - 1'b1;
    else if (cpu_ce)
      cnt_q <= (cnt_q == '0) ? rate_period(rate) - 1'b1 : cnt_q - 1'b1;
  end

  // R3: shortest period is far above one cycle, so ticks never come back to back
  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dmc_fetch.sv
module dmc_fetch
  import dmc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int CW = CNT_W,
  parameter int SC = STALL_CYC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ce,
  input  logic [DW-1:0] start_reg,
  input  logic [DW-1:0] len_reg,
  input  logic          loop_en,
  input  logic          irq_en,
  input  logic          irq_clr,
  input  logic          status_we,
  input  logic          chan_en,
  input  logic          take,
  output logic          buf_full,
  output logic [DW-1:0] buf_data,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          active,
  output logic          irq,
  output logic          stall
);
  localparam int SCW = $clog2(SC + 1);
  localparam int OFS = AW - DW - 2;

  logic [AW-1:0]  addr_q, start_addr, next_addr;
  logic [CW-1:0]  remain_q, start_cnt;
  logic [SCW-1:0] stall_q;
  logic           full_q, irq_q, hs;

  assign start_addr = {2'b11, start_reg, {OFS{1'b0}}};
  assign start_cnt  = {len_reg, 4'b0000} + CW'(1);
  assign next_addr  = (addr_q == {AW{1'b1}}) ? {1'b1, {(AW-1){1'b0}}} : addr_q + 1'b1;

  assign mem_req_valid = !full_q && (remain_q != '0);
  assign mem_req_addr  = addr_q;
  assign hs            = mem_req_valid && mem_req_ready;
  assign buf_full      = full_q;
  assign active        = remain_q != '0;
  assign irq           = irq_q;
  assign stall         = stall_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= {2'b11, {(AW-2){1'b0}}};
      remain_q <= '0;
      full_q   <= 1'b0;
      buf_data <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (hs) begin
        full_q   <= 1'b1;
        buf_data <= mem_rsp_data;
        if (remain_q == CW'(1)) begin
          if (loop_en) begin
            addr_q   <= start_addr;
            remain_q <= start_cnt;
          end else begin
            addr_q   <= next_addr;
            remain_q <= '0;
            if (irq_en) irq_q <= 1'b1;
          end
        end else begin
          addr_q   <= next_addr;
          remain_q <= remain_q - 1'b1;
        end
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (status_we) begin
        irq_q <= 1'b0;
        if (!chan_en)
          remain_q <= '0;
        else if (remain_q == '0) begin
          addr_q   <= start_addr;
          remain_q <= start_cnt;
        end
      end
      if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stall_q <= '0;
    else if (hs)
      stall_q <= SCW'(SC);
    else if (cpu_ce && stall_q != '0)
      stall_q <= stall_q - 1'b1;
  end

  // R5
  addr_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[AW-1]);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !status_we |=> mem_req_valid && $stable(mem_req_addr));
  // R6
  irq_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en));
  // R7
  irq_status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |=> !irq_q);
  // R8
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_we && !chan_en |=> !active && !mem_req_valid);
  // R9
  stall_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> stall);
endmodule

// File: rtl/dmc_output.sv
module dmc_output
  import dmc_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  input  logic          lvl_we,
  input  logic [LW-1:0] lvl_data,
  output logic          take,
  output logic [LW-1:0] level
);
  localparam int BCW = $clog2(DW) + 1;
  localparam logic [LW-1:0] TOP = LW'((1 << LW) - 2);

  logic [BCW-1:0] bits_q;
  logic [DW-1:0]  sh_q;
  logic           silent_q, last;
  logic [LW-1:0]  level_q;

  assign last  = bits_q == BCW'(1);
  assign take  = tick && last && buf_full;
  assign level = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q   <= BCW'(DW);
      sh_q     <= '0;
      silent_q <= 1'b1;
    end else if (tick) begin
      sh_q <= sh_q >> 1;
      if (last) begin
        bits_q <= BCW'(DW);
        if (buf_full) begin
          sh_q     <= buf_data;
          silent_q <= 1'b0;
        end else begin
          silent_q <= 1'b1;
        end
      end else begin
        bits_q <= bits_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q <= '0;
    else if (lvl_we)
      level_q <= lvl_data;
    else if (tick && !silent_q) begin
      if (sh_q[0] && level_q < TOP)
        level_q <= level_q + LW'(2);
      else if (!sh_q[0] && level_q > LW'(1))
        level_q <= level_q - LW'(2);
    end
  end

  // R10
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !silent_q && !lvl_we |=> (level_q == $past(level_q) + LW'(2)) ||
                                     (level_q == $past(level_q) - LW'(2)) || $stable(level_q));
  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !lvl_we |=> $stable(level_q));
  // R11
  silent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && silent_q && !lvl_we |=> $stable(level_q));
endmodule

// File: rtl/dmc_channel.sv
module dmc_channel
  import dmc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int LW = LVL_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ce,
  input  logic          ctrl_we,
  input  logic          level_we,
  input  logic          start_we,
  input  logic          length_we,
  input  logic [DW-1:0] wr_data,
  input  logic          status_we,
  input  logic          status_chan_en,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [LW-1:0] level,
  output logic          active,
  output logic          irq,
  output logic          cpu_stall
);
  logic          irq_en_q, loop_q;
  logic [RW-1:0] rate_q;
  logic [DW-1:0] start_q, len_q;
  logic          tick, take, buf_full;
  logic [DW-1:0] buf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      loop_q   <= 1'b0;
      rate_q   <= '0;
      start_q  <= '0;
      len_q    <= '0;
    end else begin
      if (ctrl_we) begin
        irq_en_q <= wr_data[7];
        loop_q   <= wr_data[6];
        rate_q   <= wr_data[RW-1:0];
      end
      if (start_we)  start_q <= wr_data;
      if (length_we) len_q   <= wr_data;
    end
  end

  dmc_rate_timer #(.RW(RW), .PW(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .rate(rate_q), .tick(tick)
  );

  dmc_fetch #(.AW(AW), .DW(DW), .CW(CNT_W), .SC(STALL_CYC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce),
    .start_reg(start_q), .len_reg(len_q), .loop_en(loop_q), .irq_en(irq_en_q),
    .irq_clr(ctrl_we && !wr_data[7]),
    .status_we(status_we), .chan_en(status_chan_en),
    .take(take), .buf_full(buf_full), .buf_data(buf_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_data(mem_rsp_data),
    .active(active), .irq(irq), .stall(cpu_stall)
  );

  dmc_output #(.DW(DW), .LW(LW)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .buf_full(buf_full), .buf_data(buf_data),
    .lvl_we(level_we), .lvl_data(wr_data[LW-1:0]), .take(take), .level(level)
  );

  // R7
  irq_ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !wr_data[7] |=> !irq);
  // R2
  level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_we |=> level == $past(wr_data[LW-1:0]));
endmodule

// File: tb/test_dmc_channel.sv
module test_dmc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 0, rst_n = 0, cpu_ce = 1;
  logic ctrl_we = 0, level_we = 0, start_we = 0, length_we = 0, status_we = 0, status_chan_en = 0;
  logic [7:0] wr_data = 0;
  logic mem_req_valid, mem_req_ready = 0;
  logic [15:0] mem_req_addr;
  logic [7:0] mem_rsp_data = 0;
  logic [6:0] level;
  logic active, irq, cpu_stall;

  dmc_channel i_dmc_channel (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, stall_cnt = 0;
  logic [7:0] tbl [16];
  logic [15:0] seen [$];
  int exp_q [$];
  int gap_q [$];
  bit ignore = 0, have_prev = 0, ce_half = 0;
  int last_cyc = 0;
  logic [6:0] prev_lvl = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (cpu_stall) stall_cnt++;
    cpu_ce = ce_half ? ~cpu_ce : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: accepts after a short delay, logs each accepted address
  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      repeat (2) @(negedge clk);
      if (mem_req_valid) begin
        mem_req_ready = 1;
        mem_rsp_data  = tbl[mem_req_addr[3:0]];
        seen.push_back(mem_req_addr);
        @(negedge clk);
        mem_req_ready = 0;
      end
    end
  end

  // monitor: every level change not caused by a direct write is popped and compared
  always @(posedge clk) begin
    #1;
    if (rst_n && level !== prev_lvl) begin
      if (!ignore) begin
        if (exp_q.size() == 0)
          chk(0, "R11 unexpected level change", level, prev_lvl);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(level == e, "R10 level step", level, e);
        end
        if (have_prev) gap_q.push_back(cyc - last_cyc);
        have_prev = 1;
        last_cyc  = cyc;
      end
      prev_lvl = level;
    end
  end

  // driver model: pushes the expected level changes of one byte
  task automatic expect_byte(input int start_lvl, input logic [7:0] b);
    int l = start_lvl;
    for (int i = 0; i < 8; i++) begin
      int n = l;
      if (b[i] && l < 126) n = l + 2;
      else if (!b[i] && l > 1) n = l - 2;
      if (n != l) exp_q.push_back(n);
      l = n;
    end
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    case (which)
      0: ctrl_we = 1;
      1: begin level_we = 1; ignore = 1; end
      2: start_we = 1;
      3: length_we = 1;
      default: begin status_we = 1; status_chan_en = d[0]; end
    endcase
    @(negedge clk);
    {ctrl_we, level_we, start_we, length_we, status_we} = '0;
    ignore = 0;
  endtask

  task automatic drain(input int per);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20 * per) @(negedge clk);
  endtask

  task automatic wait_addrs(input int n);
    while (seen.size() < n) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    for (int i = 0; i < 16; i++) tbl[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(level == 0, "R1 level", level, 0);
    chk(!irq && !active, "R1 irq/active", {irq, active}, 0);
    chk(!mem_req_valid && !cpu_stall, "R1 req/stall", {mem_req_valid, cpu_stall}, 0);
    rst_n = 1;

    // R2 direct write, bit 7 ignored
    wr(1, 8'hC5);
    chk(level == 7'h45, "R2 direct level", level, 7'h45);

    // R3 R4 R10 one byte at the fastest rate
    wr(0, 8'h0F); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h40);
    tbl[0] = 8'hA5;
    expect_byte(64, 8'hA5);
    have_prev = 0; gap_q.delete(); seen.delete();
    wr(4, 8'h01);
    chk(active == 1, "R12 active after start", active, 1);
    wait_addrs(1);
    chk(seen[0] == 16'hC000, "R4 start address", seen[0], 16'hC000);
    repeat (8) @(negedge clk);
    chk(active == 0, "R4 one byte for length 0", active, 0);
    chk(stall_cnt == 4, "R9 stall cycles", stall_cnt, 4);
    drain(54);
    chk(level == 64, "R10 final level", level, 64);
    chk(gap_q.size() > 0 && gap_q[0] == 54, "R3 period index 15", gap_q.size() ? gap_q[0] : -1, 54);
    chk(irq == 0, "R6 no irq when disabled", irq, 0);
    chk(seen.size() == 1, "R11 no refetch", seen.size(), 1);

    // R10 saturation at the top and the bottom
    wr(1, 8'd124); tbl[0] = 8'hFF; expect_byte(124, 8'hFF);
    wr(4, 8'h01); drain(54);
    chk(level == 126, "R10 upper saturation", level, 126);
    wr(1, 8'd5); tbl[0] = 8'h00; expect_byte(5, 8'h00);
    wr(4, 8'h01); drain(54);
    chk(level == 1, "R10 lower saturation", level, 1);

    // R3 slower rate index 8
    wr(0, 8'h08); wr(1, 8'd20); tbl[0] = 8'hFF; expect_byte(20, 8'hFF);
    have_prev = 0; gap_q.delete();
    wr(4, 8'h01); drain(190);
    chk(gap_q.size() > 0 && gap_q[0] == 190, "R3 period index 8", gap_q.size() ? gap_q[0] : -1, 190);
    chk(level == 36, "R10 rising run", level, 36);

    // R6 repeat, then R8 disable
    tbl[0] = 8'h00; wr(1, 8'd0); wr(0, 8'h4F); wr(2, 8'h01);
    seen.delete();
    wr(4, 8'h01);
    wait_addrs(4);
    chk(seen[0] == 16'hC040 && seen[3] == 16'hC040, "R6 repeat restarts", seen[3], 16'hC040);
    chk(active == 1, "R6 still active while repeating", active, 1);
    wr(4, 8'h00);
    chk(active == 0, "R8 disable zeroes count", active, 0);
    s0 = seen.size();
    repeat (3 * 432) @(negedge clk);
    chk(seen.size() == s0, "R8 no fetch after disable", seen.size(), s0);

    // R6 R7 interrupt set and cleared by control write
    wr(0, 8'h8F); wr(2, 8'h02);
    seen.delete();
    wr(4, 8'h01);
    wait_addrs(1); repeat (4) @(negedge clk);
    chk(seen[0] == 16'hC080, "R4 start offset", seen[0], 16'hC080);
    chk(irq == 1, "R6 irq at sample end", irq, 1);
    wr(0, 8'h0F);
    chk(irq == 0, "R7 control write clears irq", irq, 0);

    // R7 cleared by status write; R9 stall counts enabled cycles only
    wr(0, 8'h8F);
    while (exp_q.size()) @(negedge clk);
    s0 = stall_cnt;
    ce_half = 1;
    wr(4, 8'h01);
    wait_addrs(2); repeat (20) @(negedge clk);
    ce_half = 0;
    chk(stall_cnt - s0 == 7 || stall_cnt - s0 == 8, "R9 stall with gated enable", stall_cnt - s0, 8);
    chk(irq == 1, "R6 irq again", irq, 1);
    wr(4, 8'h00);
    chk(irq == 0, "R7 status write clears irq", irq, 0);

    // R5 wrap and R8 no restart while bytes remain
    wr(0, 8'h0F); wr(2, 8'hFF); wr(3, 8'h04);
    seen.delete(); s0 = stall_cnt;
    wr(4, 8'h01);
    wait_addrs(5);
    wr(4, 8'h01);
    while (active) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(seen.size() == 65, "R4 byte count", seen.size(), 65);
    chk(seen[0] == 16'hFFC0, "R5 first address", seen[0], 16'hFFC0);
    chk(seen[6] == 16'hFFC6, "R8 no restart while active", seen[6], 16'hFFC6);
    chk(seen[63] == 16'hFFFF, "R5 last before wrap", seen[63], 16'hFFFF);
    chk(seen[64] == 16'h8000, "R5 wrap address", seen[64], 16'h8000);
    chk(stall_cnt - s0 == 260, "R9 stall per fetch", stall_cnt - s0, 260);
    chk(active == 0 && !mem_req_valid, "R12 idle after end", {active, mem_req_valid}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule